// File: doc/BRIEF.md
# Per-Channel Zero-Run Detector

The block watches sixteen output channels: a left and a right channel on each of eight lanes. On every frame strobe it receives one parallel sample word per channel. For each channel it counts how many frames in a row have carried a sample that is exactly zero. Once that run reaches a programmable 8-bit threshold, the channel's flag goes high. Such a flag is typically used to mute an analog stage after the converter.

The sixteen flags come out in three forms:
- as a flat vector;
- as two status bytes;
- through a per-pin selector onto sixteen general-purpose pins.

Each general-purpose pin shows either its flag or a bit from an output register. Which one it shows depends on a direction bit and an output-select bit for that pin.

Top module: `zero_run_detector`

## Requirements
- R1: After reset the threshold register, every run counter and every flag are 0. Both status bytes read 0x00.
- R2: Flags change only on a clock edge where `frame_stb` is 1, and take effect from the following cycle. Channel n's flag is then 1 when its sample is zero and the run of zero samples, including that frame, is at least the threshold.
- R3: A frame in which a channel's sample has any bit set clears that channel's run counter and its flag in that same update. This holds for a sample of only bit 0 and for a sample of only bit 31.
- R4: With a threshold of 0, a channel's flag follows whether the current frame's sample is zero.
- R5: The run counter saturates at 255 instead of wrapping. With a threshold of 255, the flag rises on the 255th consecutive zero frame and stays high for as long as zeros continue.
- R6: Changes on `samples` while `frame_stb` is 0 have no effect on any flag.
- R7: Channel n sits at `samples[32n+31:32n]` and drives `zero_flag[n]`, with n = 2*lane + side (side 0 = left, 1 = right). `status_lo` holds flags 7..0 and `status_hi` holds flags 15..8, each in bit order. So bit 0 of `status_lo` is lane 0 left, and bit 7 of `status_hi` is lane 7 right.
- R8: For pin n, `pin_oe[n]` equals `pin_dir[n]`. `pin_out[n]` depends on the two control bits as follows:
  - `pin_dir[n]` = 1 and `pin_osel[n]` = 1: `pin_out[n]` is `zero_flag[n]`.
  - `pin_dir[n]` = 1 and `pin_osel[n]` = 0: `pin_out[n]` is `pin_oreg[n]`.
  - `pin_dir[n]` = 0: `pin_out[n]` is 0.
- R9: Channels count independently: a nonzero sample on one channel does not disturb the run of any other channel.
- R10: Writing `thr_wdata` with `thr_we` = 1 loads the threshold register at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse: a new frame of samples is present |
| samples | input | 512 | Sixteen 32-bit channel samples, channel n at bits 32n+31..32n |
| thr_we | input | 1 | Threshold register write enable |
| thr_wdata | input | 8 | Threshold value to load |
| pin_dir | input | 16 | Per-pin direction, 1 = output |
| pin_osel | input | 16 | Per-pin output select, 1 = flag, 0 = register bit |
| pin_oreg | input | 16 | Per-pin output register value |
| zero_flag | output | 16 | Per-channel zero flags |
| status_lo | output | 8 | Flags of lanes 0 to 3 |
| status_hi | output | 8 | Flags of lanes 4 to 7 |
| pin_out | output | 16 | General pin output values |
| pin_oe | output | 16 | General pin output enables |

## Verification
A table of eight frames with a threshold of 2 drives different zero masks into the channels: all zero, alternating halves, nibble groups and odd channels. These frames separate runs that just reach the threshold from runs that restart, and they show whether one channel's break leaks into its neighbours. Directed frames cover the rest:
- a threshold of 0, which exposes an off-by-one in the comparison;
- a run of 275 zero frames against a threshold of 255, which tells saturation apart from wrap-around;
- single-bit nonzero samples at both ends of the word, which catch an incomplete zero test;
- sample changes without a strobe;
- a two-flag pattern routed through the status bytes and the pin selector, which fixes the bit order.

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
  parameter int LANES = 8,
  parameter int SW    = 32,
  parameter int CW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_stb,
  input  logic [2*LANES*SW-1:0]   samples,
  input  logic                    thr_we,
  input  logic [CW-1:0]           thr_wdata,
  input  logic [2*LANES-1:0]      pin_dir,
  input  logic [2*LANES-1:0]      pin_osel,
  input  logic [2*LANES-1:0]      pin_oreg,
  output logic [2*LANES-1:0]      zero_flag,
  output logic [LANES-1:0]        status_lo,
  output logic [LANES-1:0]        status_hi,
  output logic [2*LANES-1:0]      pin_out,
  output logic [2*LANES-1:0]      pin_oe
);
  localparam int NCH = 2 * LANES;

  logic [CW-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_we) thr_q <= thr_wdata;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [CW-1:0] run_q;
    logic          flg_q;
    logic          is_zero;
    logic [CW-1:0] run_nxt;

    assign is_zero = (samples[n*SW +: SW] == '0);
    assign run_nxt = (run_q == '1) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= '0;
        flg_q <= 1'b0;
      end else if (frame_stb) begin
        if (is_zero) begin
          run_q <= run_nxt;
          flg_q <= (run_nxt >= thr_q);
        end else begin
          run_q <= '0;
          flg_q <= 1'b0;
        end
      end
    end

    assign zero_flag[n] = flg_q;
  end

  assign status_lo = zero_flag[LANES-1:0];
  assign status_hi = zero_flag[NCH-1:LANES];
  assign pin_oe    = pin_dir;
  assign pin_out   = pin_dir & ((pin_osel & zero_flag) | (~pin_osel & pin_oreg));
endmodule

// File: rtl/zero_run_detector_chk.sv
module zero_run_detector_chk #(
  parameter int NCH = 16,
  parameter int SW  = 32,
  parameter int CW  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_stb,
  input logic [NCH*SW-1:0]   samples,
  input logic [CW-1:0]       thr_q,
  input logic [NCH-1:0]      zero_flag,
  input logic [NCH-1:0]      pin_dir,
  input logic [NCH-1:0]      pin_osel,
  input logic [NCH-1:0]      pin_out,
  input logic [NCH-1:0]      pin_oe
);
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(zero_flag)); // R6

  for (genvar n = 0; n < NCH; n++) begin : g_a
    AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && (samples[n*SW +: SW] != '0) |=> !zero_flag[n]); // R3

    AST_RISE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zero_flag[n]) |-> $past(frame_stb) && ($past(samples[n*SW +: SW]) == '0)); // R2

    AST_THR_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && (thr_q == '0) && (samples[n*SW +: SW] == '0) |=> zero_flag[n]); // R4

    AST_PIN_SHOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pin_dir[n] && pin_osel[n] |-> pin_out[n] == zero_flag[n]); // R8

    AST_PIN_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_dir[n] |-> !pin_out[n] && !pin_oe[n]); // R8
  end
endmodule

bind zero_run_detector zero_run_detector_chk #(.NCH(2*LANES), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .samples(samples),
  .thr_q(thr_q), .zero_flag(zero_flag), .pin_dir(pin_dir), .pin_osel(pin_osel),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/zero_run_detector_test.sv
`timescale 1ns/1ps
module zero_run_detector_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_stb = 1'b0;
  logic [511:0] samples = '0;
  logic         thr_we = 1'b0;
  logic [7:0]   thr_wdata = '0;
  logic [15:0]  pin_dir = '0, pin_osel = '0, pin_oreg = '0;
  logic [15:0]  zero_flag, pin_out, pin_oe;
  logic [7:0]   status_lo, status_hi;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  zero_run_detector uut (.*);

  // {zero mask, expected flags} with threshold 2
  localparam logic [31:0] VEC [8] = '{
    {16'hFFFF, 16'h0000}, {16'hFFFF, 16'hFFFF}, {16'h00FF, 16'h00FF},
    {16'h0F0F, 16'h000F}, {16'h0F0F, 16'h0F0F}, {16'hAAAA, 16'h0A0A},
    {16'hAAAA, 16'hAAAA}, {16'h0000, 16'h0000}};

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] build(logic [15:0] mask);
    logic [511:0] s;
    for (int n = 0; n < 16; n++)
      s[n*32 +: 32] = mask[n] ? 32'h0 : ((32'(n) + 32'h1) << 4) | 32'h1;
    return s;
  endfunction

  task automatic frame(logic [511:0] s);
    @(negedge clk);
    samples = s;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic set_thr(logic [7:0] v);
    @(negedge clk);
    thr_we = 1'b1;
    thr_wdata = v;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", zero_flag, 16'h0);
    chk("R1 status after reset", {status_hi, status_lo}, 16'h0);

    frame(build(16'h0003));
    chk("R4 R1 threshold 0 after reset", zero_flag, 16'h0003);
    frame(build(16'h0000));
    chk("R4 nonzero clears at threshold 0", zero_flag, 16'h0000);

    set_thr(8'd2);
    frame(build(16'h0000));
    for (int i = 0; i < 8; i++) begin
      frame(build(VEC[i][31:16]));
      chk($sformatf("R2 R9 R10 vector %0d", i), zero_flag, VEC[i][15:0]);
    end

    frame(build(16'hFFFF));
    frame(build(16'hFFFF));
    chk("R2 all flags set", zero_flag, 16'hFFFF);
    s = build(16'hFFFF);
    s[31:0] = 32'h0000_0001;
    s[63:32] = 32'h8000_0000;
    frame(s);
    chk("R3 single-bit samples clear", zero_flag, 16'hFFFC);

    @(negedge clk);
    samples = build(16'h0000);
    repeat (3) @(negedge clk);
    chk("R6 no strobe no change", zero_flag, 16'hFFFC);

    set_thr(8'd255);
    frame(build(16'h0000));
    for (int i = 0; i < 254; i++) frame(build(16'h0001));
    chk("R5 254 zeros below 255", zero_flag, 16'h0000);
    frame(build(16'h0001));
    chk("R5 255th zero sets flag", zero_flag, 16'h0001);
    for (int i = 0; i < 20; i++) frame(build(16'h0001));
    chk("R5 saturated flag stays", zero_flag, 16'h0001);

    set_thr(8'd0);
    frame(build(16'h8001));
    chk("R7 flag vector", zero_flag, 16'h8001);
    chk("R7 status_lo lane0 left", {8'h0, status_lo}, 16'h0001);
    chk("R7 status_hi lane7 right", {8'h0, status_hi}, 16'h0080);

    @(negedge clk);
    pin_dir = 16'hFFFF;
    pin_osel = 16'h00FF;
    pin_oreg = 16'hA5A5;
    @(negedge clk);
    chk("R8 pin mix flag/register", pin_out, 16'hA501);
    chk("R8 pin enables", pin_oe, 16'hFFFF);
    pin_dir = 16'h0F0F;
    pin_osel = 16'hFFFF;
    @(negedge clk);
    chk("R8 inputs drive low", pin_out, 16'h0001);
    chk("R8 inputs not enabled", pin_oe, 16'h0F0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule